// File: doc/BRIEF.md
# Cache Line Maintenance Controller

This block carries out one maintenance command at a time on a single line of a data cache whose line states follow MESI. The commands are store-back, flush, allocate, zero and invalidate. A command arrives with its target address and the context that decides the outcome: the tag lookup result (hit and current state), two protection-check flags (one for load-style access and one for store-style access), a coherency-required attribute, a user-mode bit, a data-breakpoint match and the cache-enable bit. All of this is sampled in the cycle the command is accepted.

The controller works out which actions the command needs. It may request a write-back of the dirty line and an address-only broadcast on the system bus. It then finishes with a one-cycle completion strobe. The same strobe cycle carries the line state update, the request to establish a zeroed line, or a data-storage exception. Write-back and broadcast each use a request/acknowledge pair. The write-back always comes before the broadcast.

Top module: `cache_line_maint_ctrl`

## Requirements
- R1: A flush (op 1) that hits a Modified line (state 3) requests a write-back, then updates the line to Invalid (state 0).
- R2: A flush that hits an Exclusive (2) or Shared (1) line updates it to Invalid with no write-back. A flush or store-back that misses (no hit, or state 0) makes no line update and no write-back.
- R3: A store-back (op 0) that hits a Modified line requests a write-back, then updates the line to Exclusive. On an Exclusive or Shared hit it takes no cache action.
- R4: With coherency required, a flush issues a bus broadcast with bus_flush=1, and a store-back issues one with bus_flush=0. Any broadcast follows the write-back.
- R5: With the cache disabled, no command writes back, updates or establishes a line. Broadcasts for coherent store-back and flush are still issued.
- R6: Store-back and flush fault on the load-style protection flag. Invalidate and zero fault on the store-style flag. A faulting command raises dsi_exc with done and takes no other action, including no broadcast.
- R7: An invalidate (op 4) that hits a line in any valid state, Modified included, updates it to Invalid with no write-back. A miss does nothing.
- R8: An invalidate issued with user_mode=1 faults.
- R9: A zero (op 3) on an enabled cache raises alloc_req at completion. It faults on the store-style protection flag or on a breakpoint match.
- R10: An allocate (op 2) behaves like zero. In every case where zero would fault, it instead completes with no action and no exception.
- R11: cmd_ready is high only when idle. done lasts one cycle and comes one cycle after acceptance or after the last acknowledge. With no handshake the command completes in the cycle after acceptance.
- R12: wb_req and bus_req stay high until acknowledged, with tgt_addr stable and equal to the accepted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command taken when valid |
| cmd_op | input | 3 | 0 store-back, 1 flush, 2 allocate, 3 zero, 4 invalidate |
| cmd_addr | input | AW | Target line address |
| tag_hit | input | 1 | Lookup hit |
| tag_state | input | 2 | Current line state: 0 I, 1 S, 2 E, 3 M |
| prot_ld_fault | input | 1 | Protection violation when checked as a load |
| prot_st_fault | input | 1 | Protection violation when checked as a store |
| coh_req | input | 1 | Target requires memory coherency |
| user_mode | input | 1 | Command issued at user level |
| dc_enable | input | 1 | Data cache enabled |
| bkpt_hit | input | 1 | Data-breakpoint address match |
| wb_req | output | 1 | Write-back of the line requested |
| wb_ack | input | 1 | Write-back accepted |
| bus_req | output | 1 | Address-only bus broadcast requested |
| bus_flush | output | 1 | Broadcast kind: 1 flush, 0 plain address |
| bus_ack | input | 1 | Broadcast accepted |
| tgt_addr | output | AW | Address of the command in progress |
| line_wr | output | 1 | Line state update strobe |
| line_state | output | 2 | New line state for line_wr |
| alloc_req | output | 1 | Establish a zeroed line strobe |
| dsi_exc | output | 1 | Data-storage exception strobe |
| done | output | 1 | Command complete strobe |

## Verification
Each request appears in the first cycle after acceptance, or after the acknowledge that ends the previous phase. done and its strobes appear one cycle after the last acknowledge. The bench therefore expects done at a cycle index equal to the sum of (ack delay + 1) over the phases it predicts. It drives inputs and acknowledges just after the falling edge and samples there too, so each value it reads is the state settled by the preceding rising edge. Acknowledge delays of zero and several cycles are both used, so that holding a request and completing the same cycle are each observed.

// File: rtl/cache_line_maint_ctrl.sv
module cache_line_maint_ctrl #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic          tag_hit,
  input  logic [1:0]    tag_state,
  input  logic          prot_ld_fault,
  input  logic          prot_st_fault,
  input  logic          coh_req,
  input  logic          user_mode,
  input  logic          dc_enable,
  input  logic          bkpt_hit,
  output logic          wb_req,
  input  logic          wb_ack,
  output logic          bus_req,
  output logic          bus_flush,
  input  logic          bus_ack,
  output logic [AW-1:0] tgt_addr,
  output logic          line_wr,
  output logic [1:0]    line_state,
  output logic          alloc_req,
  output logic          dsi_exc,
  output logic          done
);
  localparam logic [2:0] OP_SB = 3'd0, OP_FL = 3'd1, OP_AL = 3'd2, OP_ZO = 3'd3, OP_IV = 3'd4;
  localparam logic [1:0] ST_I = 2'd0, ST_E = 2'd2, ST_M = 2'd3;

  typedef enum logic [1:0] {IDLE, WBK, BCAST, FIN} phase_t;
  phase_t ph;

  logic [AW-1:0] addr_q;
  logic wb_q, bus_q, fl_q, upd_q, alloc_q, flt_q;
  logic [1:0] nst_q;

  wire is_sb = cmd_op == OP_SB;
  wire is_fl = cmd_op == OP_FL;
  wire is_al = cmd_op == OP_AL;
  wire is_zo = cmd_op == OP_ZO;
  wire is_iv = cmd_op == OP_IV;

  wire zo_bad  = prot_st_fault | bkpt_hit;
  wire fault   = ((is_sb | is_fl) & prot_ld_fault) | (is_iv & (prot_st_fault | user_mode)) | (is_zo & zo_bad);
  wire act     = !fault && !(is_al && zo_bad);
  wire valid_h = act && dc_enable && tag_hit && tag_state != ST_I;
  wire dirty   = tag_state == ST_M;
  wire n_wb    = valid_h && dirty && (is_sb || is_fl);
  wire n_upd   = valid_h && (is_fl || is_iv || (is_sb && dirty));
  wire n_alloc = act && dc_enable && (is_al || is_zo);
  wire n_bus   = act && coh_req && (is_sb || is_fl);
  wire accept  = cmd_valid && cmd_ready;

  assign cmd_ready  = ph == IDLE;
  assign wb_req     = ph == WBK;
  assign bus_req    = ph == BCAST;
  assign done       = ph == FIN;
  assign bus_flush  = fl_q;
  assign tgt_addr   = addr_q;
  assign line_wr    = done && upd_q;
  assign line_state = nst_q;
  assign alloc_req  = done && alloc_q;
  assign dsi_exc    = done && flt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= IDLE;
      addr_q <= '0;
      {wb_q, bus_q, fl_q, upd_q, alloc_q, flt_q} <= '0;
      nst_q <= ST_I;
    end else begin
      unique case (ph)
        IDLE: if (accept) begin
          addr_q  <= cmd_addr;
          wb_q    <= n_wb;
          bus_q   <= n_bus;
          fl_q    <= is_fl;
          upd_q   <= n_upd;
          nst_q   <= is_sb ? ST_E : ST_I;
          alloc_q <= n_alloc;
          flt_q   <= fault;
          ph      <= n_wb ? WBK : (n_bus ? BCAST : FIN);
        end
        WBK:   if (wb_ack) ph <= bus_q ? BCAST : FIN;
        BCAST: if (bus_ack) ph <= FIN;
        FIN:   ph <= IDLE;
      endcase
    end
  end

  a_r12_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(tgt_addr));
  a_r12_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(tgt_addr) && $stable(bus_flush));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && cmd_ready);
  a_r11_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past((wb_req && wb_ack) || (bus_req && bus_ack) || (cmd_valid && cmd_ready)));
  a_r4_bus_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !wb_req && !cmd_ready);
  a_r6_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dsi_exc |-> !line_wr && !alloc_req);
  a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !wb_req && !bus_req && !done);
endmodule

// File: tb/test_cache_line_maint_ctrl.sv
`timescale 1ns/1ps
module test_cache_line_maint_ctrl;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [2:0] cmd_op = 0;
  logic [31:0] cmd_addr = 0;
  logic tag_hit = 0, prot_ld_fault = 0, prot_st_fault = 0, coh_req = 0, user_mode = 0, dc_enable = 0, bkpt_hit = 0;
  logic [1:0] tag_state = 0;
  logic wb_req, wb_ack = 0, bus_req, bus_flush, bus_ack = 0;
  logic [31:0] tgt_addr;
  logic line_wr, alloc_req, dsi_exc, done;
  logic [1:0] line_state;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cache_line_maint_ctrl #(.AW(32)) i_cache_line_maint_ctrl (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_addr, .tag_hit, .tag_state,
    .prot_ld_fault, .prot_st_fault, .coh_req, .user_mode, .dc_enable, .bkpt_hit,
    .wb_req, .wb_ack, .bus_req, .bus_flush, .bus_ack, .tgt_addr,
    .line_wr, .line_state, .alloc_req, .dsi_exc, .done);

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run(string req, int op, bit hit, int st, bit pld, bit pst, bit coh,
                     bit usr, bit en, bit bk, int dly);
    bit e_wb = 0, e_bus = 0, e_wr = 0, e_al = 0, e_dsi = 0;
    int e_ns = 0;
    bit s_wb = 0, s_bus = 0, s_kind = 0, order_bad = 0, busy_ready = 0, addr_bad = 0;
    bit g_wr = 0, g_al = 0, g_dsi = 0, g_done = 0;
    int g_ns = 0, g_cyc = -1, wc = 0, bc = 0, e_cyc;
    bit live = (hit && st != 0);
    logic [31:0] a = 32'h1000_0000 + 32'(total * 64);
    case (op)
      0: if (pld) e_dsi = 1; else begin
           e_bus = coh;
           if (en && live && st == 3) begin e_wb = 1; e_wr = 1; e_ns = 2; end
         end
      1: if (pld) e_dsi = 1; else begin
           e_bus = coh;
           if (en && live) begin e_wr = 1; e_ns = 0; e_wb = (st == 3); end
         end
      2: if (!(pst || bk)) e_al = en;
      3: if (pst || bk) e_dsi = 1; else e_al = en;
      4: if (pst || usr) e_dsi = 1; else if (en && live) begin e_wr = 1; e_ns = 0; end
      default: ;
    endcase
    e_cyc = (e_wb ? dly + 1 : 0) + (e_bus ? dly + 1 : 0);
    @(negedge clk);
    cmd_op = 3'(op); cmd_addr = a; tag_hit = hit; tag_state = 2'(st);
    prot_ld_fault = pld; prot_st_fault = pst; coh_req = coh; user_mode = usr;
    dc_enable = en; bkpt_hit = bk; cmd_valid = 1;
    chk("R11", {req, " ready idle"}, int'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 0;
    for (int c = 0; c < 60; c++) begin
      if (c > 0) @(negedge clk);
      wb_ack = 0; bus_ack = 0;
      if (cmd_ready) busy_ready = 1;
      if (done) begin
        g_done = 1; g_cyc = c; g_wr = line_wr; g_ns = int'(line_state);
        g_al = alloc_req; g_dsi = dsi_exc;
        break;
      end
      if (tgt_addr != a) addr_bad = 1;
      if (wb_req) begin
        s_wb = 1;
        if (s_bus) order_bad = 1;
        if (wc == dly) wb_ack = 1; else wc++;
      end
      if (bus_req) begin
        s_bus = 1; s_kind = bus_flush;
        if (e_wb && !s_wb) order_bad = 1;
        if (bc == dly) bus_ack = 1; else bc++;
      end
    end
    chk(req, "done seen", int'(g_done), 1);
    chk(req, "done cycle", g_cyc, e_cyc);
    chk(req, "write-back", int'(s_wb), int'(e_wb));
    chk(req, "broadcast", int'(s_bus), int'(e_bus));
    if (e_bus) chk(req, "broadcast kind", int'(s_kind), int'(op == 1));
    chk(req, "line update", int'(g_wr), int'(e_wr));
    if (e_wr) chk(req, "new state", g_ns, e_ns);
    chk(req, "alloc", int'(g_al), int'(e_al));
    chk(req, "exception", int'(g_dsi), int'(e_dsi));
    chk("R4", {req, " wb before bus"}, int'(order_bad), 0);
    chk("R11", {req, " ready low while busy"}, int'(busy_ready), 0);
    chk("R12", {req, " address held"}, int'(addr_bad), 0);
  endtask

  task automatic t_flush;
    run("R1 flush M", 1, 1, 3, 0, 0, 0, 0, 1, 0, 0);
    run("R1 flush M slow ack", 1, 1, 3, 0, 0, 0, 0, 1, 0, 3);
    run("R2 flush E", 1, 1, 2, 0, 0, 0, 0, 1, 0, 0);
    run("R2 flush S", 1, 1, 1, 0, 0, 0, 0, 1, 0, 0);
    run("R2 flush miss", 1, 0, 3, 0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_storeback;
    run("R3 store-back M", 0, 1, 3, 0, 0, 0, 0, 1, 0, 2);
    run("R3 store-back E", 0, 1, 2, 0, 0, 0, 0, 1, 0, 0);
    run("R3 store-back S", 0, 1, 1, 0, 0, 0, 0, 1, 0, 0);
    run("R2 store-back miss", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_coherent;
    run("R4 flush M coherent", 1, 1, 3, 0, 0, 1, 0, 1, 0, 1);
    run("R4 store-back M coherent", 0, 1, 3, 0, 0, 1, 0, 1, 0, 0);
    run("R4 flush miss coherent", 1, 0, 0, 0, 0, 1, 0, 1, 0, 2);
  endtask

  task automatic t_disabled;
    run("R5 flush M disabled", 1, 1, 3, 0, 0, 0, 0, 0, 0, 0);
    run("R5 store-back coherent disabled", 0, 1, 3, 0, 0, 1, 0, 0, 0, 0);
    run("R5 invalidate disabled", 4, 1, 3, 0, 0, 0, 0, 0, 0, 0);
    run("R5 zero disabled", 3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_protect;
    run("R6 flush load fault", 1, 1, 3, 1, 0, 1, 0, 1, 0, 0);
    run("R6 flush store flag ignored", 1, 1, 2, 0, 1, 0, 0, 1, 0, 0);
    run("R6 store-back load fault", 0, 1, 3, 1, 0, 1, 0, 1, 0, 0);
    run("R6 invalidate store fault", 4, 1, 2, 0, 1, 0, 0, 1, 0, 0);
    run("R6 invalidate load flag ignored", 4, 1, 2, 1, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_invalidate;
    run("R7 invalidate M", 4, 1, 3, 0, 0, 1, 0, 1, 0, 0);
    run("R7 invalidate S", 4, 1, 1, 0, 0, 0, 0, 1, 0, 0);
    run("R7 invalidate miss", 4, 0, 2, 0, 0, 0, 0, 1, 0, 0);
    run("R8 invalidate user", 4, 1, 3, 0, 0, 0, 1, 1, 0, 0);
  endtask

  task automatic t_zero_alloc;
    run("R9 zero", 3, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    run("R9 zero store fault", 3, 0, 0, 0, 1, 0, 0, 1, 0, 0);
    run("R9 zero breakpoint", 3, 1, 2, 0, 0, 0, 0, 1, 1, 0);
    run("R10 allocate", 2, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    run("R10 allocate store fault", 2, 0, 0, 0, 1, 0, 0, 1, 0, 0);
    run("R10 allocate breakpoint", 2, 1, 3, 0, 0, 0, 0, 1, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "reset ready", int'(cmd_ready), 1);
    chk("R11", "reset done", int'(done), 0);
    chk("R12", "reset wb_req", int'(wb_req), 0);
    rst_n = 1;
    t_flush;
    t_storeback;
    t_coherent;
    t_disabled;
    t_protect;
    t_invalidate;
    t_zero_alloc;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule